// File: doc/BRIEF.md
# Serial Command Word Receiver with Chain Pass-Through

This block is the slave end of a four-wire serial link (select, clock, data in, data out) that feeds a register-controlled core. While select is low it shifts data in MSB first on every rising serial-clock edge. When select returns high it looks at how many bits arrived. A frame whose length is a nonzero multiple of 16 is decoded into a 4-bit command, a 4-bit address and an 8-bit data field, and the block raises a one-cycle execute strobe. A select pulse with no clock edges re-issues the last executed word. Any other length is dropped.

The data-out line repeats the incoming stream 16 clocks later, so several receivers can share one chain. After the core performs a read, it loads the result into the low byte of the shift register. That byte then leaves on data-out during the next frame. All serial pins are brought through a synchronizer into the system clock domain, so serial clock rates must be well below the system clock.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A word is 16 bits sent MSB first and sampled on rising serial-clock edges. Decoded, bits 15:12 are the command, bits 11:8 the address and bits 7:0 the data.
- R2: Serial clock idle-low (mode 0) and idle-high (mode 3) framing give the same decoded words and the same data-out stream.
- R3: `exec_o` is a single system-clock pulse after select rises on an accepted frame. `cmd_o`, `addr_o` and `data_o` change only in that cycle and hold their value otherwise.
- R4: A frame of 16, 32 or 48 bits is accepted. The decoded word is the last 16 bits shifted in.
- R5: A bit count that is not a multiple of 4 causes no execution and clears the shift register to zero, so the next frame's data-out starts with 16 zero bits.
- R6: A bit count that is a multiple of 4 but not of 16 causes no execution and leaves the shifted bits in the register.
- R7: A select low/high pulse with no clock edges repeats the last accepted word. `exec_o` pulses and the outputs keep that word, even when rejected frames came in between.
- R8: Until a frame has been accepted after reset, a select pulse without clock edges causes no execution.
- R9: Before each rising clock edge, data-out carries the bit that entered data-in 16 rising edges earlier, counted across frames. It updates after falling clock edges and when select falls.
- R10: `rb_load_i` while select is high writes `rb_data_i` into shift-register bits 7:0 and keeps bits 15:8. While select is low it is ignored.
- R11: `sdo_oe_o` is low whenever select is high, and `sdo_o` never changes while released.
- R12: After reset `exec_o`, `sdo_oe_o`, `sdo_o` and all decoded outputs are 0, and the shift register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data in |
| rb_load_i | input | 1 | Readback load strobe from the core |
| rb_data_i | input | 8 | Readback byte |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Data-out drive enable (low = released) |
| exec_o | output | 1 | Execute strobe |
| cmd_o | output | 4 | Decoded command |
| addr_o | output | 4 | Decoded address |
| data_o | output | 8 | Decoded data |

## Verification
The assertions check four properties on every cycle:
- the execute strobe lasts one cycle;
- the decoded fields move only together with that strobe;
- the strobe never comes while data-out is driven;
- data-out stays frozen while released.

Only the bench scenarios can show the rest:
- the stream arithmetic: the 16-clock delay across frames, and the difference between wiped and kept register contents after rejected lengths;
- replay of the last accepted word and its suppression before the first accepted frame;
- a readback byte emerging on data-out.

The bench sweeps frame lengths from 1 to 48 bits and alternates both clock polarities.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = CMD_W + ADDR_W + DATA_W;
    localparam int GROUP_W = 4;   // bit-count granularity that keeps contents

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } word_t;

    // Outcome of a frame, judged from its bit count at select rise
    typedef enum logic [1:0] {
        V_EMPTY  = 2'd0,   // no clock edges: replay candidate
        V_RAGGED = 2'd1,   // not a multiple of GROUP_W: wipe
        V_SHORT  = 2'd2,   // multiple of GROUP_W, not of WORD_W: keep
        V_WHOLE  = 2'd3    // nonzero multiple of WORD_W: execute
    } verdict_t;

    function automatic verdict_t judge(input int n);
        if (n == 0)                 return V_EMPTY;
        else if (n % GROUP_W != 0)  return V_RAGGED;
        else if (n % WORD_W != 0)   return V_SHORT;
        else                        return V_WHOLE;
    endfunction
endpackage

// File: rtl/scf_pin_sync.sv
module scf_pin_sync #(
    parameter int STAGES = 2   // at least 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic sdi_s
);
    // lane order: {sdi, cs_n, sclk}; select resets to idle (high)
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0]             pins;
    logic [STAGES-1:0][2:0] chain;
    logic [2:0]             prev;
    logic [2:0]             now;

    assign pins = {sdi_i, cs_n_i, sclk_i};
    assign now  = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE}};
            prev  <= IDLE;
        end else begin
            chain <= {chain[STAGES-2:0], pins};
            prev  <= now;
        end
    end

    assign sclk_rise =  now[0] & ~prev[0];
    assign sclk_fall = ~now[0] &  prev[0];
    assign cs_fall   = ~now[1] &  prev[1];
    assign cs_rise   =  now[1] & ~prev[1];
    assign cs_low    = ~now[1];
    assign sdi_s     =  now[2];
endmodule

// File: rtl/scf_shifter.sv
module scf_shifter
    import scf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_i,
    input  logic              show_en,
    input  logic              wipe_i,
    input  logic              cs_low_i,
    input  logic              rb_load_i,
    input  logic [DATA_W-1:0] rb_data_i,
    output word_t             word_o,
    output logic              sdo_o
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            sdo_o <= 1'b0;
        end else begin
            if (wipe_i)
                sr <= '0;
            else if (shift_en)
                sr <= {sr[WORD_W-2:0], bit_i};
            else if (rb_load_i && !cs_low_i)
                sr[DATA_W-1:0] <= rb_data_i;
            // oldest bit is presented ahead of the next rising edge
            if (show_en)
                sdo_o <= sr[WORD_W-1];
        end
    end

    assign word_o = word_t'(sr);
endmodule

// File: rtl/scf_decider.sv
module scf_decider
    import scf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  cs_fall,
    input  logic  cs_rise,
    input  word_t word_i,
    output logic  exec_o,
    output word_t frame_o,
    output logic  wipe_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             armed;
    verdict_t         verdict;

    always_comb verdict = judge(int'(cnt));

    assign wipe_o = cs_rise && (verdict == V_RAGGED);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            armed   <= 1'b0;
            exec_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            exec_o <= 1'b0;
            if (cs_fall || cs_rise)
                cnt <= '0;
            else if (shift_en && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;   // saturated count judges as ragged
            if (cs_rise) begin
                if (verdict == V_WHOLE) begin
                    frame_o <= word_i;
                    armed   <= 1'b1;
                    exec_o  <= 1'b1;
                end else if (verdict == V_EMPTY && armed) begin
                    exec_o  <= 1'b1;   // frame_o already holds last word
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
    import scf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    input  logic              rb_load_i,
    input  logic [DATA_W-1:0] rb_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              exec_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    logic  sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, sdi_s;
    logic  shift_en, show_en, wipe;
    word_t word, frame;

    scf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .sdi_i     (sdi_i),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_low    (cs_low),
        .sdi_s     (sdi_s)
    );

    assign shift_en = sclk_rise & cs_low;
    assign show_en  = (sclk_fall & cs_low) | cs_fall;

    scf_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .bit_i     (sdi_s),
        .show_en   (show_en),
        .wipe_i    (wipe),
        .cs_low_i  (cs_low),
        .rb_load_i (rb_load_i),
        .rb_data_i (rb_data_i),
        .word_o    (word),
        .sdo_o     (sdo_o)
    );

    scf_decider #(.CNT_W(CNT_W)) u_decide (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .word_i   (word),
        .exec_o   (exec_o),
        .frame_o  (frame),
        .wipe_o   (wipe)
    );

    assign sdo_oe_o = cs_low;
    assign cmd_o    = frame.cmd;
    assign addr_o   = frame.addr;
    assign data_o   = frame.data;
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
    import scf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic              exec_o,
    input logic [CMD_W-1:0]  cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o
);
    // R3
    exec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        exec_o |=> !exec_o);

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_o |-> $stable({cmd_o, addr_o, data_o}));

    // R3
    exec_released_chk: assert property (@(posedge clk) disable iff (rst)
        exec_o |-> !sdo_oe_o);

    // R11
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo_o) |-> $past(sdo_oe_o));

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!exec_o && !sdo_oe_o));
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .exec_o   (exec_o),
    .cmd_o    (cmd_o),
    .addr_o   (addr_o),
    .data_o   (data_o)
);

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb;
    import scf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       rb_load = 1'b0;
    logic [7:0] rb_data = 8'h00;
    logic       sdo_o, sdo_oe_o, exec_o;
    logic [3:0] cmd_o, addr_o;
    logic [7:0] data_o;

    spi_cmd_frontend u_dut (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .sdi_i     (sdi),
        .rb_load_i (rb_load),
        .rb_data_i (rb_data),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o),
        .exec_o    (exec_o),
        .cmd_o     (cmd_o),
        .addr_o    (addr_o),
        .data_o    (data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          exec_seen = 0;
    logic [15:0] cap = 16'h0;

    // bench model
    logic [15:0] m_sr = 16'h0;
    logic [15:0] m_last = 16'h0;
    bit          m_armed = 1'b0;
    int          m_exec = 0;

    always @(negedge clk) begin
        if (exec_o) begin
            exec_seen++;
            cap = {cmd_o, addr_o, data_o};
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_exec(input string req);
        check(exec_seen == m_exec, req, "execute count",
              64'(exec_seen), 64'(m_exec));
        check({cmd_o, addr_o, data_o} == m_last, {req, " R3"}, "decoded word",
              64'({cmd_o, addr_o, data_o}), 64'(m_last));
    endtask

    task automatic frame(input int n, input logic [63:0] vec, input bit mode3,
                         input bit rb_mid, input string req);
        logic [127:0] full;
        logic [63:0]  mask;
        logic [63:0]  got;
        logic [63:0]  exp;
        bit           oe_ok;
        mask  = (64'd1 << n) - 64'd1;
        full  = ({112'b0, m_sr} << n) | {64'b0, vec & mask};
        exp   = full[79:16];
        got   = '0;
        oe_ok = 1'b1;
        sclk = mode3;
        tick(HALF);
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = vec[n-1-i];
            tick(HALF);
            got = {got[62:0], sdo_o};
            if (!sdo_oe_o) oe_ok = 1'b0;
            if (rb_mid && i == 3) begin
                rb_data = 8'hFF;
                rb_load = 1'b1;
                tick(1);
                rb_load = 1'b0;
            end
            sclk = 1'b1;
            tick(HALF);
        end
        if (!mode3) sclk = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(10);
        check(got == exp, {req, " R9"}, "data-out stream", got, exp);
        check(oe_ok, "R11", "drive enable during frame", 64'(oe_ok), 64'd1);
        check(sdo_oe_o == 1'b0, "R11", "drive enable after frame",
              64'(sdo_oe_o), 64'd0);
        if (n % 16 == 0) begin
            m_sr = full[15:0];
            m_last = full[15:0];
            m_armed = 1'b1;
            m_exec++;
        end else if (n % 4 == 0) begin
            m_sr = full[15:0];
        end else begin
            m_sr = 16'h0;
        end
        check_exec(req);
    endtask

    task automatic bare_pulse(input string req);
        cs_n = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(10);
        if (m_armed) begin
            m_exec++;
            check(cap == m_last, req, "replayed word", 64'(cap), 64'(m_last));
        end
        check_exec(req);
    endtask

    task automatic rb_idle(input logic [7:0] val);
        rb_data = val;
        rb_load = 1'b1;
        tick(1);
        rb_load = 1'b0;
        tick(2);
        m_sr[7:0] = val;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        // R12 reset state
        check(exec_o == 1'b0, "R12", "exec after reset", 64'(exec_o), 64'd0);
        check({cmd_o, addr_o, data_o} == 16'h0, "R12", "fields after reset",
              64'({cmd_o, addr_o, data_o}), 64'd0);
        check(sdo_oe_o == 1'b0, "R12", "enable after reset", 64'(sdo_oe_o), 64'd0);
        check(sdo_o == 1'b0, "R12", "data-out after reset", 64'(sdo_o), 64'd0);

        // R8: no replay before an accepted frame, even after a rejected one
        bare_pulse("R8");
        frame(8, 64'hC3, 1'b0, 1'b0, "R6");
        bare_pulse("R8");

        // R1 / R2: word sweep alternating clock polarity
        for (int k = 0; k < 16; k++) begin
            logic [15:0] w;
            w = 16'(k * 16'h1357 + 16'h0A5C);
            frame(16, 64'(w), k[0], 1'b0, k[0] ? "R2" : "R1");
        end

        // R7: replay
        bare_pulse("R7");
        bare_pulse("R7");

        // R4: chained frames
        frame(32, 64'hBEEF_4C21, 1'b0, 1'b0, "R4");
        frame(32, 64'h1F2E_D3C4, 1'b1, 1'b0, "R4");

        // R4 / R5 / R6: every length from 1 to 48 bits
        for (int n = 1; n <= 48; n++) begin
            string req;
            req = (n % 16 == 0) ? "R4" : ((n % 4 == 0) ? "R6" : "R5");
            frame(n, 64'hA5C3_96F0_1E2D_7B48 ^ 64'(n * 7), n[0], 1'b0, req);
            if (n == 20) bare_pulse("R7");
        end

        // R10: readback load while released, ignored while selected
        frame(16, 64'h9A00, 1'b0, 1'b0, "R10");
        rb_idle(8'h3C);
        frame(16, 64'h1234, 1'b1, 1'b1, "R10");
        frame(16, 64'h5678, 1'b0, 1'b0, "R10");

        summary();
        $finish;
    end
endmodule